// File: doc/BRIEF.md
# Policy-Selectable Single-Resource Arbiter

This block decides which of N requesters gets one shared resource in a given cycle. It takes a request vector and returns a one-hot grant in the same cycle. The priority policy is fixed when the block is elaborated, through a parameter. The three choices are a rotating round-robin pointer, a least-recently-served matrix, and a fixed-priority order whose grant path is built as a grouped lookahead instead of a ripple chain.

A caller that actually consumes the grant raises an update strobe in that cycle. The priority state then advances at the next rising clock edge. A grant that is not consumed leaves the state untouched, so a requester that was not served keeps its place. The block is meant to be instantiated many times inside virtual-channel and crossbar allocators.

The reset input is asynchronous and active-low. It is released through a two-stage synchroniser inside the block.

Top module: `sel_arbiter`

## Requirements
- R1: `grant` has at most one bit set, and a set bit only ever stands at a position where `req` is also set.
- R2: `grant` is all-zero exactly when `req` is all-zero.
- R3: `grant` depends on `req` and the stored state within the same cycle, with no register between them.
- R4: Round-robin policy (POLICY=POL_RR): after reset the search pointer is 0. The grant goes to the first requester found at or above the pointer, and the search wraps from index N-1 back to index 0.
- R5: Round-robin policy: after a used grant to index k, the pointer becomes k+1, or 0 when k is N-1.
- R6: Matrix policy (POLICY=POL_MATRIX): after reset, a lower index beats every higher index.
- R7: Matrix policy: after a used grant to index w, w loses to every other requester. The relative order among all the other requesters is unchanged.
- R8: Lookahead policy (POLICY=POL_LOOKAHEAD): the lowest-indexed active requester always wins, whatever grants went before. A higher index can therefore be starved indefinitely.
- R9: Priority state changes only on a rising edge where `upd` is 1 and `grant` is nonzero. `upd` with no request, or a grant without `upd`, leaves the next arbitration unchanged.
- R10: Driving `rst_n` low resets the priority state at once, without waiting for a clock edge. The state leaves reset two rising edges after `rst_n` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N | One request bit per requester |
| upd | input | 1 | The current grant is consumed; advance the priority state |
| grant | output | N | One-hot grant, or all-zero when nothing is requested |

## Verification
The grant is due in the same cycle as the request. The bench drives `req` and `upd` on the falling edge and compares the grant 1 ns later, before the next rising edge, which exercises the combinational path of R3.

The effect of a used grant is due at the following rising edge. The bench's reference models for pointer, recency order and fixed order therefore apply each update only after pushing the current expectation, so the next queued item sees the advanced state.

Reset is checked half a nanosecond after `rst_n` falls, away from any edge. Traffic resumes three cycles after release, which covers the two-edge synchroniser.

// File: rtl/arb_pol_pkg.sv
package arb_pol_pkg;

  typedef enum logic [1:0] {
    POL_RR        = 2'd0,
    POL_MATRIX    = 2'd1,
    POL_LOOKAHEAD = 2'd2
  } arb_policy_e;

endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/arb_rr_core.sv
module arb_rr_core #(
  parameter int N  = 8,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic [N-1:0] req,
  input  logic         upd,
  output logic [N-1:0] grant
);

  logic [PW-1:0] ptr_q, ptr_d;
  logic          ptr_en;
  logic          found;
  int            gidx;

  // search from the pointer upward, wrapping at N
  always_comb begin
    found = 1'b0;
    gidx  = 0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = int'(ptr_q) + k;
      if (c >= N) c = c - N;
      if (!found && req[c]) begin
        found = 1'b1;
        gidx  = c;
      end
    end
    grant = '0;
    if (found) grant[gidx] = 1'b1;
  end

  assign ptr_en = upd && found;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_en) begin
      if (gidx == N - 1) ptr_d = '0;
      else               ptr_d = PW'(gidx + 1);
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  for (genvar k = 0; k < N; k++) begin : g_chk
    AST_RR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_sn)
      (upd && grant[k]) |=> (ptr_q == PW'((k + 1) % N)))
      else $error("pointer did not move past granted index"); // R5
  end

  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    !(upd && (|grant)) |=> $stable(ptr_q))
    else $error("pointer moved without a used grant"); // R9

endmodule

// File: rtl/arb_matrix_core.sv
module arb_matrix_core #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic [N-1:0] req,
  input  logic         upd,
  output logic [N-1:0] grant
);

  // prio_q[i][j] == 1 : i wins against j
  logic [N-1:0][N-1:0] prio_q, prio_d;
  logic                mtx_en;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != i && req[j] && prio_q[j][i]) beaten = 1'b1;
      end
      grant[i] = req[i] && !beaten;
    end
  end

  assign mtx_en = upd && (|grant);

  always_comb begin
    prio_d = prio_q;
    for (int w = 0; w < N; w++) begin
      if (grant[w]) begin
        for (int j = 0; j < N; j++) begin
          if (j != w) begin
            prio_d[w][j] = 1'b0;
            prio_d[j][w] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          prio_q[i][j] <= (i < j);
    end else if (mtx_en) begin
      prio_q <= prio_d;
    end
  end

  for (genvar w = 0; w < N; w++) begin : g_chk
    AST_MTX_LOSER: assert property (@(posedge clk) disable iff (!rst_sn)
      (upd && grant[w]) |=> (prio_q[w] == '0))
      else $error("served requester still beats someone"); // R7
  end

  AST_MTX_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    !(upd && (|grant)) |=> $stable(prio_q))
    else $error("matrix changed without a used grant"); // R9

endmodule

// File: rtl/arb_lookahead_core.sv
module arb_lookahead_core #(
  parameter int N   = 8,
  parameter int GRP = 4,
  localparam int NG = (N + GRP - 1) / GRP,
  localparam int NP = NG * GRP
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  logic [NP-1:0] req_p, grant_p;
  logic [NG-1:0] grp_any, grp_clear;

  always_comb begin
    req_p        = '0;
    req_p[N-1:0] = req;
  end

  // group-level lookahead: each group learns in one OR level
  // whether any lower group holds a request
  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_any[g] = |req_p[g*GRP +: GRP];

    always_comb begin
      grp_clear[g] = 1'b1;
      for (int h = 0; h < g; h++) begin
        if (grp_any[h]) grp_clear[g] = 1'b0;
      end
    end

    for (genvar b = 0; b < GRP; b++) begin : g_bit
      logic below;
      always_comb begin
        below = 1'b0;
        for (int m = 0; m < b; m++) begin
          if (req_p[g*GRP + m]) below = 1'b1;
        end
      end
      assign grant_p[g*GRP + b] = req_p[g*GRP + b] && !below && grp_clear[g];
    end
  end

  assign grant = grant_p[N-1:0];

  for (genvar i = 1; i < N; i++) begin : g_chk
    AST_LA_LOWEST: assert property (@(posedge clk) disable iff (!rst_sn)
      grant[i] |-> (req[i-1:0] == '0))
      else $error("a lower index was passed over"); // R8
  end

endmodule

// File: rtl/sel_arbiter.sv
module sel_arbiter
  import arb_pol_pkg::*;
#(
  parameter int          N      = 8,
  parameter arb_policy_e POLICY = POL_RR,
  parameter int          GRP    = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         upd,
  output logic [N-1:0] grant
);

  logic rst_sn;

  arb_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  if (POLICY == POL_MATRIX) begin : g_mtx
    arb_matrix_core #(.N(N)) u_core (
      .clk    (clk),
      .rst_sn (rst_sn),
      .req    (req),
      .upd    (upd),
      .grant  (grant)
    );
  end else if (POLICY == POL_LOOKAHEAD) begin : g_la
    logic upd_unused;
    assign upd_unused = upd;
    arb_lookahead_core #(.N(N), .GRP(GRP)) u_core (
      .clk    (clk),
      .rst_sn (rst_sn),
      .req    (req),
      .grant  (grant)
    );
  end else begin : g_rr
    arb_rr_core #(.N(N)) u_core (
      .clk    (clk),
      .rst_sn (rst_sn),
      .req    (req),
      .upd    (upd),
      .grant  (grant)
    );
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(grant))
    else $error("more than one grant"); // R1

  AST_GNT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_sn)
    (grant & ~req) == '0)
    else $error("grant to a non-requester"); // R1

  AST_GNT_IFF_REQ: assert property (@(posedge clk) disable iff (!rst_sn)
    (|grant) == (|req))
    else $error("grant/request emptiness mismatch"); // R2

endmodule

// File: tb/sim_sel_arbiter.sv
`timescale 1ns/1ps
module sim_sel_arbiter;
  import arb_pol_pkg::*;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic         upd;
  logic [N-1:0] gnt [3];

  always #2 clk = ~clk;

  for (genvar p = 0; p < 3; p++) begin : g_pol
    sel_arbiter #(.N(N), .POLICY(arb_policy_e'(p))) u0 (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .upd   (upd),
      .grant (gnt[p])
    );
  end

  typedef struct {
    logic [N-1:0] r;
    logic [N-1:0] e [3];
    string        tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   rr_ptr;
  int   ord [N];

  task automatic check(input logic [N-1:0] got, input logic [N-1:0] exp,
                       input string tag, input int pol);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s policy %0d: actual %b expected %b", tag, pol, got, exp);
    end
  endtask

  task automatic model_reset();
    rr_ptr = 0;
    for (int k = 0; k < N; k++) ord[k] = k;
  endtask

  function automatic logic [N-1:0] ref_rr(input logic [N-1:0] r);
    for (int k = 0; k < N; k++) begin
      int c = (rr_ptr + k) % N;
      if (r[c]) return N'(1) << c;
    end
    return '0;
  endfunction

  function automatic logic [N-1:0] ref_mx(input logic [N-1:0] r);
    for (int k = 0; k < N; k++)
      if (r[ord[k]]) return N'(1) << ord[k];
    return '0;
  endfunction

  function automatic logic [N-1:0] ref_la(input logic [N-1:0] r);
    for (int k = 0; k < N; k++)
      if (r[k]) return N'(1) << k;
    return '0;
  endfunction

  function automatic int idx_of(input logic [N-1:0] v);
    for (int k = 0; k < N; k++) if (v[k]) return k;
    return 0;
  endfunction

  // driver: apply stimulus on falling edge, push expectation, advance models
  task automatic step(input logic [N-1:0] r, input logic u, input string tag);
    exp_t x;
    @(negedge clk);
    req = r;
    upd = u;
    x.r    = r;
    x.e[0] = ref_rr(r);
    x.e[1] = ref_mx(r);
    x.e[2] = ref_la(r);
    x.tag  = tag;
    q.push_back(x);
    if (u && x.e[0] != '0) rr_ptr = (idx_of(x.e[0]) + 1) % N;
    if (u && x.e[1] != '0) begin
      int w = idx_of(x.e[1]);
      int pos = 0;
      for (int k = 0; k < N; k++) if (ord[k] == w) pos = k;
      for (int k = pos; k < N - 1; k++) ord[k] = ord[k+1];
      ord[N-1] = w;
    end
  endtask

  // monitor: compare 1 ns after each falling edge (same cycle, R3)
  always @(negedge clk) begin
    exp_t x;
    #1;
    if (q.size() > 0) begin
      x = q.pop_front();
      for (int p = 0; p < 3; p++) begin
        check(gnt[p], x.e[p], x.tag, p);
        n_chk++;
        if (!$onehot0(gnt[p]) || ((gnt[p] & ~x.r) != '0) ||
            ((|gnt[p]) != (|x.r))) begin
          n_bad++;
          $display("FAIL R1 R2 policy %0d: actual %b expected subset of %b",
                   p, gnt[p], x.r);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0;
    req   = '0;
    upd   = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state: R4 pointer at 0, R6 low index first, R8 fixed order
    step('1, 1'b0, "R4 R6 R10");
    step(8'b1010_0000, 1'b0, "R4 R6");
    // update with no requests is ignored (R9, R2)
    step('0, 1'b1, "R2 R9");
    step('1, 1'b0, "R9");
    // used grant advances state (R5, R7)
    step('1, 1'b1, "R5 R7");
    step('1, 1'b0, "R5 R7");
    // grant not consumed: nothing moves (R9)
    step(8'b0000_0110, 1'b0, "R9");
    step(8'b0000_0110, 1'b0, "R9");
    // wrap of the round-robin pointer (R4, R5)
    step(8'b1000_0000, 1'b1, "R5");
    step(8'b1000_0001, 1'b0, "R4 R5");
    step(8'b1000_0010, 1'b1, "R4");
    // matrix order preservation (R7)
    step(8'b0001_1000, 1'b1, "R7");
    step(8'b0011_1000, 1'b1, "R7");
    step(8'b0011_1000, 1'b1, "R7");
    step(8'b0011_1000, 1'b0, "R7");
    // lookahead starvation of the high index (R8)
    for (int k = 0; k < 6; k++) step(8'b1000_0001, 1'b1, "R8");
    // pseudo-random traffic
    lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[7:0], lf[9] | lf[11], "R5 R7 R8");
    end

    // asynchronous reset mid-cycle (R10)
    @(negedge clk);
    req = '1;
    upd = 1'b0;
    #1;
    rst_n = 1'b0;
    #0.5;
    for (int p = 0; p < 3; p++) check(gnt[p], 8'b0000_0001, "R10 async", p);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    step('1, 1'b1, "R10");
    step('1, 1'b1, "R5 R7");
    step(8'b0000_0011, 1'b0, "R5 R7 R8");

    repeat (2) @(negedge clk);
    #2;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule